// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block models a small on-chip flash array together with the 8-bit control register that sequences its program and erase operations. A simple CPU-style bus writes and reads the control register through one strobe and writes the array through a second strobe. Both strobes share one address and one write-data bus. An erased cell reads as 1 and a programmed cell reads as 0. Programming can therefore only clear bits. Only an erase, either of one aligned 64-byte page or of the whole array, sets bits back to 1.

Software first selects a mode (program or erase, with an optional mass-erase qualifier). It then makes one dummy array write that latches the target address, and only after that sets the high-voltage enable. The sequencer state machine has these states: `ST_IDLE` (no usable mode), `ST_MODE_SEL` (mode chosen, target not latched), `ST_ARMED` (target latched), `ST_PROGRAM` (high voltage on in program mode), `ST_ERASING` (erase timer running, `busy` high) and `ST_ERASE_DONE` (erase applied, high voltage still on). The transitions are as follows:
- A mode write moves to `ST_MODE_SEL` if exactly one of program/erase is set, and to `ST_IDLE` otherwise.
- A latching array write moves `ST_MODE_SEL` or `ST_ARMED` to `ST_ARMED`.
- A high-voltage write moves `ST_ARMED` to `ST_PROGRAM` or `ST_ERASING`.
- Timer expiry moves `ST_ERASING` to `ST_ERASE_DONE`.
- A write with the high-voltage bit at 0 moves any high-voltage state back to `ST_MODE_SEL`.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After reset `ctl_rdata` is 0x00, `busy` is 0, `arr_rdata` is 0xFF and every array byte reads 0xFF.
- R2: Control register layout: bit 3 is high-voltage enable, bit 2 mass select, bit 1 erase select, bit 0 program select. Bits 7..4 always read 0.
- R3: The high-voltage bit becomes 1 only when it is written while exactly one of program/erase is already stored and an array write has latched a target since the last mode write. Otherwise the high-voltage bit of that write is ignored and its bits 2..0 are stored.
- R4: While high voltage is on, a control write cannot change bits 2..0. A write with bit 3 at 0 clears only the high-voltage bit. The mode bits may be cleared by a later write.
- R5: In program mode with high voltage on, an array write whose address lies in the same aligned 32-byte row as the latched target stores old AND new. Writes to any other row are ignored.
- R6: Array writes made while no program cycle is active (high voltage off, or erase mode) leave the array unchanged. An array write in the same cycle as a control write is ignored.
- R7: A page erase holds `busy` high for exactly ERASE_CYCLES cycles, starting at the edge that sets high voltage. It then sets every byte of the aligned 64-byte page holding the latched target to 0xFF and leaves all other bytes unchanged. The high-voltage bit stays 1 until it is cleared.
- R8: With mass and erase both selected, the erase sets every array byte to 0xFF.
- R9: Clearing the high-voltage bit while `busy` is high aborts the erase: `busy` is 0 from the next cycle and the array is unchanged.
- R10: `arr_rdata` shows the byte at `bus_addr` one clock after the address is presented. It holds its value while `busy` is high.
- R11: Leaving a high-voltage state discards the latched target. A new latching array write is needed before high voltage can be set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| arr_we | input | 1 | Array write strobe (program data or target latch) |
| bus_addr | input | AW | Array byte address for writes and reads |
| bus_wdata | input | 8 | Write data for control register or array |
| ctl_rdata | output | 8 | Control register read value |
| arr_rdata | output | 8 | Registered array read data |
| busy | output | 1 | Erase in progress |

## Verification
Control writes are reflected on `ctl_rdata` right after the edge that captures them, so the bench reads the register at the falling edge that follows each write. Array read data is due one clock after the address is set, and program writes are visible to a read issued on the next cycle. The bench counts the falling edges at which `busy` is high after the enabling write and expects exactly ERASE_CYCLES of them. After an abort write, `busy` must already be low at the next falling edge. All samples are taken at falling edges, away from the capturing edge, and the array is compared byte by byte against a bench model after each phase.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE_SEL,
        ST_ARMED,
        ST_PROGRAM,
        ST_ERASING,
        ST_ERASE_DONE
    } nvm_state_e;

    localparam int unsigned CB_HV    = 3;
    localparam int unsigned CB_MASS  = 2;
    localparam int unsigned CB_ERASE = 1;
    localparam int unsigned CB_PGM   = 0;

    typedef struct packed {
        logic mass;
        logic erase;
        logic pgm;
    } nvm_mode_t;

    function automatic logic mode_usable(input nvm_mode_t m);
        return m.pgm ^ m.erase;
    endfunction

endpackage

// File: rtl/nvm_erase_timer.sv
module nvm_erase_timer #(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign done = run && (cnt_q == LAST);

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST)); // R7

endmodule

// File: rtl/nvm_ctl_fsm.sv
module nvm_ctl_fsm
    import nvm_pe_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned ROW_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    input  logic          arr_we,
    input  logic [AW-1:0] arr_addr,
    input  logic          tmr_done,
    output logic [7:0]    ctl_rdata,
    output logic          tmr_run,
    output logic          busy,
    output logic          prog_we,
    output logic          page_erase,
    output logic          mass_erase,
    output logic [AW-1:0] target_addr
);
    localparam int unsigned ROW_LSB = $clog2(ROW_BYTES);

    nvm_state_e    state_q, state_d;
    nvm_mode_t     mode_q, mode_d;
    logic [AW-1:0] tgt_q, tgt_d;

    logic      hv_req;
    nvm_mode_t wr_mode;
    logic      hv_on;
    logic      hv_drop;
    logic      row_hit;
    logic      erase_go;

    assign hv_req  = ctl_wdata[CB_HV];
    assign wr_mode = nvm_mode_t'(ctl_wdata[CB_MASS:CB_PGM]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            tgt_q   <= tgt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            ST_IDLE, ST_MODE_SEL, ST_ARMED: begin
                if (ctl_we) begin
                    if (hv_req && (state_q == ST_ARMED)) begin
                        state_d = mode_q.pgm ? ST_PROGRAM : ST_ERASING;
                    end else begin
                        mode_d  = wr_mode;
                        state_d = mode_usable(wr_mode) ? ST_MODE_SEL : ST_IDLE;
                    end
                end else if (arr_we && (state_q != ST_IDLE)) begin
                    tgt_d   = arr_addr;
                    state_d = ST_ARMED;
                end
            end
            ST_PROGRAM, ST_ERASE_DONE: begin
                if (ctl_we && !hv_req) begin
                    state_d = ST_MODE_SEL;
                end
            end
            ST_ERASING: begin
                if (ctl_we && !hv_req) begin
                    state_d = ST_MODE_SEL;
                end else if (tmr_done) begin
                    state_d = ST_ERASE_DONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        hv_on       = (state_q == ST_PROGRAM) || (state_q == ST_ERASING) ||
                      (state_q == ST_ERASE_DONE);
        ctl_rdata   = {4'b0000, hv_on, mode_q.mass, mode_q.erase, mode_q.pgm};
        busy        = (state_q == ST_ERASING);
        tmr_run     = busy;
        hv_drop     = ctl_we && !hv_req;
        row_hit     = (arr_addr[AW-1:ROW_LSB] == tgt_q[AW-1:ROW_LSB]);
        prog_we     = (state_q == ST_PROGRAM) && arr_we && !ctl_we && row_hit;
        erase_go    = busy && tmr_done && !hv_drop;
        page_erase  = erase_go && !mode_q.mass;
        mass_erase  = erase_go && mode_q.mass;
        target_addr = tgt_q;
    end

    AST_HV_NEEDS_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        hv_on |-> mode_usable(mode_q)); // R3

    AST_HV_ONLY_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_on) |-> ($past(state_q) == ST_ARMED)); // R3

    AST_MODE_FROZEN_UNDER_HV: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_on && ctl_we) |=> $stable(mode_q)); // R4

    AST_HV_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_on && ctl_we && !ctl_wdata[CB_HV]) |=> (state_q == ST_MODE_SEL)); // R9

    AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> !busy); // R6

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int unsigned BYTES      = 256,
    parameter int unsigned PAGE_BYTES = 64,
    parameter int unsigned AW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_we,
    input  logic          page_erase,
    input  logic          mass_erase,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] erase_base,
    input  logic          rd_hold,
    output logic [7:0]    rdata
);
    localparam int unsigned PG_LSB = $clog2(PAGE_BYTES);

    logic [7:0] cells [BYTES];
    logic [7:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                cells[i] <= 8'hFF;
            end
            rdata_q <= 8'hFF;
        end else begin
            if (mass_erase) begin
                for (int i = 0; i < BYTES; i++) begin
                    cells[i] <= 8'hFF;
                end
            end else if (page_erase) begin
                for (int i = 0; i < BYTES; i++) begin
                    if ((AW'(i) >> PG_LSB) == (erase_base >> PG_LSB)) begin
                        cells[i] <= 8'hFF;
                    end
                end
            end else if (prog_we) begin
                cells[addr] <= cells[addr] & wdata;
            end
            if (!rd_hold) begin
                rdata_q <= cells[addr];
            end
        end
    end

    assign rdata = rdata_q;

    AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_we, page_erase, mass_erase})); // R6

endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl #(
    parameter int unsigned ARRAY_BYTES  = 256,
    parameter int unsigned PAGE_BYTES   = 64,
    parameter int unsigned ROW_BYTES    = 32,
    parameter int unsigned ERASE_CYCLES = 20,
    localparam int unsigned AW          = $clog2(ARRAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          arr_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    ctl_rdata,
    output logic [7:0]    arr_rdata,
    output logic          busy
);
    logic          tmr_run;
    logic          tmr_done;
    logic          prog_we;
    logic          page_erase;
    logic          mass_erase;
    logic [AW-1:0] target_addr;

    nvm_ctl_fsm #(
        .AW        (AW),
        .ROW_BYTES (ROW_BYTES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_wdata   (bus_wdata),
        .arr_we      (arr_we),
        .arr_addr    (bus_addr),
        .tmr_done    (tmr_done),
        .ctl_rdata   (ctl_rdata),
        .tmr_run     (tmr_run),
        .busy        (busy),
        .prog_we     (prog_we),
        .page_erase  (page_erase),
        .mass_erase  (mass_erase),
        .target_addr (target_addr)
    );

    nvm_erase_timer #(
        .CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    nvm_cell_array #(
        .BYTES      (ARRAY_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .AW         (AW)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .page_erase (page_erase),
        .mass_erase (mass_erase),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .erase_base (target_addr),
        .rd_hold    (busy),
        .rdata      (arr_rdata)
    );

    AST_RDATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_rdata)); // R10

    AST_BUSY_IN_ERASE_HV: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_rdata[1] && ctl_rdata[3] && !ctl_rdata[0])); // R7

endmodule

// File: tb/nvm_pe_ctrl_tb.sv
module nvm_pe_ctrl_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NBYTES     = 256;
    localparam int unsigned ERASE_CYC  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic       arr_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] ctl_rdata;
    logic [7:0] arr_rdata;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [7:0] model [NBYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_pe_ctrl #(
        .ARRAY_BYTES  (NBYTES),
        .PAGE_BYTES   (64),
        .ROW_BYTES    (32),
        .ERASE_CYCLES (ERASE_CYC)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .arr_we    (arr_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctl_rdata (ctl_rdata),
        .arr_rdata (arr_rdata),
        .busy      (busy)
    );

    function automatic logic [7:0] f_prog(input logic [7:0] old_v, input logic [7:0] new_v);
        return old_v & new_v;
    endfunction

    function automatic bit f_same_row(input logic [7:0] a, input logic [7:0] b);
        return a[7:5] == b[7:5];
    endfunction

    function automatic bit f_same_page(input logic [7:0] a, input logic [7:0] b);
        return a[7:6] == b[7:6];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic ctl_wr(input logic [7:0] d);
        ctl_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic arr_wr(input logic [7:0] a, input logic [7:0] d);
        arr_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        arr_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        @(negedge clk);
        v = arr_rdata;
    endtask

    task automatic cmp_all(input string tag);
        logic [7:0] v;
        for (int a = 0; a < NBYTES; a++) begin
            rd(8'(a), v);
            chk(v == model[a], tag, v, model[a]);
        end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Program a few random bytes within the row holding base.
    task automatic prog_row(input logic [7:0] base, input int cnt);
        logic [7:0] a;
        logic [7:0] d;
        ctl_wr(8'h01);
        arr_wr(base, 8'hFF);
        ctl_wr(8'h09);
        for (int k = 0; k < cnt; k++) begin
            a = {base[7:5], 5'($urandom)};
            d = 8'($urandom);
            arr_wr(a, d);
            model[a] = f_prog(model[a], d);
        end
        ctl_wr(8'h01);
        ctl_wr(8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] r0;
        logic [7:0] a;
        logic [7:0] d;
        int n;
        void'($urandom(32'd4711));
        for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ctl_rdata == 8'h00, "R1 ctl after reset", ctl_rdata, 8'h00);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(arr_rdata == 8'hFF, "R1 rdata after reset", arr_rdata, 8'hFF);
        cmp_all("R1 array erased at reset");

        // R2: layout, upper bits read zero
        ctl_wr(8'hF2);
        chk(ctl_rdata == 8'h02, "R2 upper bits zero", ctl_rdata, 8'h02);
        ctl_wr(8'h04);
        chk(ctl_rdata == 8'h04, "R2 mass bit position", ctl_rdata, 8'h04);
        ctl_wr(8'h00);
        chk(ctl_rdata == 8'h00, "R2 clear", ctl_rdata, 8'h00);

        // R3: HV refused without prior mode / latch / unique mode
        ctl_wr(8'h09);
        chk(ctl_rdata == 8'h01, "R3 hv with mode in same write", ctl_rdata, 8'h01);
        ctl_wr(8'h09);
        chk(ctl_rdata == 8'h01, "R3 hv without latch", ctl_rdata, 8'h01);
        ctl_wr(8'h03);
        arr_wr(8'h10, 8'h00);
        ctl_wr(8'h0B);
        chk(ctl_rdata == 8'h03, "R3 hv with both modes", ctl_rdata, 8'h03);
        ctl_wr(8'h00);

        // R6: dummy latch write and writes without a program cycle
        ctl_wr(8'h01);
        arr_wr(8'h45, 8'h00);
        rd(8'h45, v);
        chk(v == 8'hFF, "R6 latch write leaves data", v, 8'hFF);
        ctl_wr(8'h09);
        chk(ctl_rdata == 8'h09, "R3 hv accepted after sequence", ctl_rdata, 8'h09);

        // R5: random programming inside and outside the latched row
        for (int k = 0; k < 24; k++) begin
            a = {3'b010, 5'($urandom)};
            d = 8'($urandom);
            arr_wr(a, d);
            model[a] = f_prog(model[a], d);
            rd(a, v);
            chk(v == model[a], "R10 R5 read after program", v, model[a]);
        end
        for (int k = 0; k < 8; k++) begin
            a = 8'h80 | 8'($urandom & 32'h7F);
            if (f_same_row(a, 8'h45)) a = 8'hC0;
            arr_wr(a, 8'h00);
            rd(a, v);
            chk(v == model[a], "R5 write outside row ignored", v, model[a]);
        end
        arr_wr(8'h46, 8'h0F);
        model[8'h46] = f_prog(model[8'h46], 8'h0F);
        arr_wr(8'h46, 8'hF3);
        model[8'h46] = f_prog(model[8'h46], 8'hF3);
        rd(8'h46, v);
        chk(v == model[8'h46], "R5 program only clears bits", v, model[8'h46]);

        // R4: mode frozen under HV, HV clear keeps mode
        ctl_wr(8'h0A);
        chk(ctl_rdata == 8'h09, "R4 mode change under hv ignored", ctl_rdata, 8'h09);
        ctl_wr(8'h00);
        chk(ctl_rdata == 8'h01, "R4 hv clear keeps mode", ctl_rdata, 8'h01);
        ctl_wr(8'h00);
        chk(ctl_rdata == 8'h00, "R4 mode cleared later", ctl_rdata, 8'h00);

        // R11: latch lost after leaving HV
        ctl_wr(8'h01);
        arr_wr(8'h22, 8'hFF);
        ctl_wr(8'h09);
        ctl_wr(8'h01);
        ctl_wr(8'h09);
        chk(ctl_rdata == 8'h01, "R11 relatch needed", ctl_rdata, 8'h01);
        arr_wr(8'h22, 8'h55);
        rd(8'h22, v);
        chk(v == 8'hFF, "R6 write with hv off ignored", v, 8'hFF);
        ctl_wr(8'h00);

        // R6: random writes with no mode
        for (int k = 0; k < 16; k++) begin
            arr_wr(8'($urandom), 8'($urandom));
        end
        cmp_all("R6 no mode writes ignored");

        // Seed data in several pages
        prog_row(8'h80, 12);
        prog_row(8'hA0, 12);
        prog_row(8'hC0, 12);
        prog_row(8'h00, 12);

        // R7: page erase
        ctl_wr(8'h02);
        arr_wr(8'h8A, 8'h00);
        ctl_wr(8'h0A);
        r0 = arr_rdata;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            bus_addr = 8'($urandom);
            @(negedge clk);
            if (busy) chk(arr_rdata == r0, "R10 rdata held while busy", arr_rdata, r0);
        end
        chk(n == ERASE_CYC, "R7 busy length", n, ERASE_CYC);
        chk(ctl_rdata == 8'h0A, "R7 hv stays after erase", ctl_rdata, 8'h0A);
        for (int i = 0; i < NBYTES; i++)
            if (f_same_page(8'(i), 8'h8A)) model[i] = 8'hFF;
        arr_wr(8'h00, 8'h00);
        arr_wr(8'h8A, 8'h00);
        ctl_wr(8'h02);
        ctl_wr(8'h00);
        cmp_all("R7 R6 page erase result");

        // R9: abort
        ctl_wr(8'h02);
        arr_wr(8'hC4, 8'h00);
        ctl_wr(8'h0A);
        chk(busy == 1'b1, "R7 busy starts", busy, 1);
        repeat (5) @(negedge clk);
        ctl_wr(8'h02);
        chk(busy == 1'b0, "R9 busy drops on abort", busy, 0);
        chk(ctl_rdata == 8'h02, "R9 hv cleared", ctl_rdata, 8'h02);
        repeat (ERASE_CYC) @(negedge clk);
        ctl_wr(8'h00);
        cmp_all("R9 abort leaves array");

        // R8: mass erase
        ctl_wr(8'h06);
        arr_wr(8'h01, 8'h00);
        ctl_wr(8'h0E);
        count_busy(n);
        chk(n == ERASE_CYC, "R8 mass busy length", n, ERASE_CYC);
        ctl_wr(8'h06);
        ctl_wr(8'h00);
        for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
        cmp_all("R8 mass erase result");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule